// File: doc/BRIEF.md
# Dual-Port Tagged Semaphore Register

This block keeps a small set of hardware semaphores in one shared register that two requesters can reach: a backplane-side port and a local processor port. Each semaphore is one byte with a lock flag and an owner tag. A requester claims a semaphore by writing its own tag with the lock flag set and then reading the register back. If the tag it reads matches the one it wrote, it holds the semaphore. Otherwise another requester got there first.

Writes to a held semaphore are ignored. Only the port that claimed a semaphore can release it, and a release clears the byte. Each write port has a write strobe and per-byte enables, so one write can touch any subset of the semaphores. When both ports try to claim the same free semaphore in the same clock, the backplane port wins. Both read paths show the whole register at all times. Address decoding and bus protocol belong to the surrounding logic, which hands this block one decoded write strobe per port.

Top module: `sem_reg_top`

## Requirements
- R1: After reset every semaphore byte is 0x00, and both read ports return 0x00000000.
- R2: Semaphore k sits in bits 8k+7:8k of the register. Bit 7 of each byte is the lock flag and bits 6:0 are the tag.
- R3: A write whose lock bit is 1, to a free semaphore, stores the written tag and sets the lock. Both read ports show the new byte from the clock after the write.
- R4: A write whose lock bit is 1, to a locked semaphore, has no effect, whichever port issues it.
- R5: A write whose lock bit is 0, from the port that claimed a locked semaphore, releases it. The byte reads 0x00 afterwards.
- R6: A write whose lock bit is 0, from the port that did not claim the semaphore, is ignored.
- R7: A write whose lock bit is 0, to a free semaphore, leaves it at 0x00.
- R8: A write changes only the bytes whose byte enable is 1 (enable bit k selects semaphore k). A cycle with no enabled write leaves the whole register unchanged.
- R9: If both ports claim the same free semaphore in one clock, the backplane port's tag is stored. It becomes the owner and the local write is dropped.
- R10: Every decision uses the state held at the start of the clock. If the owner releases a semaphore while the other port claims it in the same clock, the semaphore ends up free.
- R11: Both read ports always return all four bytes of the current state, whatever the byte enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_we | input | 1 | Backplane port write strobe (register decoded) |
| bus_be | input | 4 | Backplane port byte enables, one per semaphore |
| bus_wdata | input | 32 | Backplane port write data |
| bus_rdata | output | 32 | Backplane port read data, full register |
| loc_we | input | 1 | Local port write strobe (register decoded) |
| loc_be | input | 4 | Local port byte enables, one per semaphore |
| loc_wdata | input | 32 | Local port write data |
| loc_rdata | output | 32 | Local port read data, full register |

## Verification
The assertions assume that each write strobe and its byte enables and data are stable for the whole clock in which they are sampled. They also assume that nothing is written while the internal reset is still held, so that every change of state comes from a single sampled write. The bench drives all inputs on the falling edge and writes only after the synchronised reset has been released. It then walks through the contested cases: a same-clock claim by both ports, a same-clock release and claim, and foreign releases. After that it applies random traffic with a narrow set of tags so that collisions happen often.

// File: rtl/sem_reg_pkg.sv
package sem_reg_pkg;
  typedef enum logic {
    OWN_BUS = 1'b0,
    OWN_LOC = 1'b1
  } sem_owner_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sem_slot.sv
module sem_slot
  import sem_reg_pkg::*;
#(
  parameter int TAG_W = 7,
  localparam int SEM_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [SEM_W-1:0] bus_byte,
  input  logic             loc_wr,
  input  logic [SEM_W-1:0] loc_byte,
  output logic [SEM_W-1:0] sem_byte
);
  logic             lock_q, lock_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  sem_owner_e       owner_q, owner_d;
  logic             upd_en;

  logic bus_acq, bus_rel, loc_acq, loc_rel, owner_rel;

  assign bus_acq   = bus_wr &  bus_byte[SEM_W-1];
  assign bus_rel   = bus_wr & ~bus_byte[SEM_W-1];
  assign loc_acq   = loc_wr &  loc_byte[SEM_W-1];
  assign loc_rel   = loc_wr & ~loc_byte[SEM_W-1];
  assign owner_rel = (owner_q == OWN_BUS) ? bus_rel : loc_rel;

  always_comb begin
    lock_d  = lock_q;
    tag_d   = tag_q;
    owner_d = owner_q;
    upd_en  = 1'b0;
    if (!lock_q) begin
      if (bus_acq) begin
        lock_d  = 1'b1;
        tag_d   = bus_byte[TAG_W-1:0];
        owner_d = OWN_BUS;
        upd_en  = 1'b1;
      end else if (loc_acq) begin
        lock_d  = 1'b1;
        tag_d   = loc_byte[TAG_W-1:0];
        owner_d = OWN_LOC;
        upd_en  = 1'b1;
      end
    end else if (owner_rel) begin
      lock_d  = 1'b0;
      tag_d   = '0;
      owner_d = OWN_BUS;
      upd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      tag_q   <= '0;
      owner_q <= OWN_BUS;
    end else if (upd_en) begin
      lock_q  <= lock_d;
      tag_q   <= tag_d;
      owner_q <= owner_d;
    end
  end

  assign sem_byte = {lock_q, tag_q};

  // R3
  bus_acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sem_byte[SEM_W-1] && bus_acq) |=> (sem_byte == $past(bus_byte)) && (owner_q == OWN_BUS));

  // R4
  held_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_byte[SEM_W-1] && !(bus_rel && owner_q == OWN_BUS) && !(loc_rel && owner_q == OWN_LOC))
      |=> $stable(sem_byte) && $stable(owner_q));

  // R5
  owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_byte[SEM_W-1] && owner_q == OWN_LOC && loc_rel) |=> (sem_byte == '0));

  // R6
  foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_byte[SEM_W-1] && owner_q == OWN_BUS && loc_rel && !bus_rel) |=> sem_byte[SEM_W-1]);

  // R7
  free_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sem_byte[SEM_W-1] && !bus_acq && !loc_acq) |=> (sem_byte == '0));

  // R9
  bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sem_byte[SEM_W-1] && bus_acq && loc_acq) |=> (owner_q == OWN_BUS));
endmodule

// File: rtl/sem_reg_top.sv
module sem_reg_top #(
  parameter int NUM_SEM = 4,
  parameter int TAG_W   = 7,
  localparam int SEM_W  = TAG_W + 1,
  localparam int DATA_W = NUM_SEM * SEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [NUM_SEM-1:0] bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               loc_we,
  input  logic [NUM_SEM-1:0] loc_be,
  input  logic [DATA_W-1:0]  loc_wdata,
  output logic [DATA_W-1:0]  loc_rdata
);
  logic              rst_n_int;
  logic [DATA_W-1:0] sem_vec;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_slot
    sem_slot #(.TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .bus_wr   (bus_we & bus_be[k]),
      .bus_byte (bus_wdata[k*SEM_W +: SEM_W]),
      .loc_wr   (loc_we & loc_be[k]),
      .loc_byte (loc_wdata[k*SEM_W +: SEM_W]),
      .sem_byte (sem_vec[k*SEM_W +: SEM_W])
    );
  end

  assign bus_rdata = sem_vec;
  assign loc_rdata = sem_vec;

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((!bus_we || bus_be == '0) && (!loc_we || loc_be == '0)) |=> $stable(bus_rdata));
endmodule

// File: tb/sim_sem_reg_top.sv
module sim_sem_reg_top;
  logic        clk;
  logic        rst_n;
  logic        b_we, l_we;
  logic [3:0]  b_be, l_be;
  logic [31:0] b_wd, l_wd;
  logic [31:0] b_rd, l_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_lock [4];
  int m_tag  [4];
  int m_own  [4];

  sem_reg_top u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_we(b_we), .bus_be(b_be), .bus_wdata(b_wd), .bus_rdata(b_rd),
    .loc_we(l_we), .loc_be(l_be), .loc_wdata(l_wd), .loc_rdata(l_rd)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference: own=0 backplane, own=1 local
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      automatic bit bw = b_we && b_be[k];
      automatic bit lw = l_we && l_be[k];
      automatic int bb = (b_wd >> (8*k)) & 255;
      automatic int lb = (l_wd >> (8*k)) & 255;
      if (m_lock[k] == 0) begin
        if (bw && bb >= 128) begin m_lock[k] = 1; m_tag[k] = bb & 127; m_own[k] = 0; end
        else if (lw && lb >= 128) begin m_lock[k] = 1; m_tag[k] = lb & 127; m_own[k] = 1; end
      end else begin
        if ((m_own[k] == 0 && bw && bb < 128) || (m_own[k] == 1 && lw && lb < 128)) begin
          m_lock[k] = 0; m_tag[k] = 0; m_own[k] = 0;
        end
      end
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'((m_lock[k] << 7) | m_tag[k]);
    return w;
  endfunction

  task automatic compare(string req);
    logic [31:0] exp = model_word();
    checks++;
    if (b_rd !== exp) begin
      errors++;
      $display("FAIL %s bus_rdata actual %08h expected %08h", req, b_rd, exp);
    end
    checks++;
    if (l_rd !== exp) begin
      errors++;
      $display("FAIL %s loc_rdata actual %08h expected %08h", req, l_rd, exp);
    end
  endtask

  task automatic step(string req, bit bwe, logic [3:0] bbe, logic [31:0] bwd,
                      bit lwe, logic [3:0] lbe, logic [31:0] lwd);
    b_we = bwe; b_be = bbe; b_wd = bwd;
    l_we = lwe; l_be = lbe; l_wd = lwd;
    @(negedge clk);
    compare(req);
  endtask

  task automatic expect_word(string req, logic [31:0] exp);
    checks++;
    if (b_rd !== exp) begin
      errors++;
      $display("FAIL %s directed value actual %08h expected %08h", req, b_rd, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_lock[k] = 0; m_tag[k] = 0; m_own[k] = 0; end
    rst_n = 0;
    b_we = 0; b_be = 0; b_wd = 0; l_we = 0; l_be = 0; l_wd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1");
    expect_word("R1", 32'h0);

    // R3 backplane claims semaphore 0 with tag 0x15
    step("R3", 1, 4'b0001, 32'h0000_0095, 0, 4'b0000, 32'h0);
    expect_word("R3", 32'h0000_0095);
    // R4 local claim on held semaphore ignored
    step("R4", 0, 4'b0000, 32'h0, 1, 4'b0001, 32'h0000_00A2);
    expect_word("R4", 32'h0000_0095);
    // R6 local release of backplane-owned semaphore ignored
    step("R6", 0, 4'b0000, 32'h0, 1, 4'b0001, 32'h0000_0000);
    expect_word("R6", 32'h0000_0095);
    // R4 owner re-claim with other tag ignored
    step("R4", 1, 4'b0001, 32'h0000_00C7, 0, 4'b0000, 32'h0);
    expect_word("R4", 32'h0000_0095);
    // R8 only semaphore 2 touched
    step("R8", 0, 4'b0000, 32'h0, 1, 4'b0100, 32'hFFB3_FFFF);
    expect_word("R8", 32'h00B3_0095);
    // R5 owner releases semaphore 0
    step("R5", 1, 4'b0001, 32'h0000_0000, 0, 4'b0000, 32'h0);
    expect_word("R5", 32'h00B3_0000);
    // R7 lock-zero write to free semaphore 1
    step("R7", 1, 4'b0010, 32'h0000_0500, 1, 4'b0010, 32'h0000_0600);
    expect_word("R7", 32'h00B3_0000);
    // R9 both claim semaphore 1, backplane wins
    step("R9", 1, 4'b0010, 32'h0000_8100, 1, 4'b0010, 32'h0000_8200);
    expect_word("R9", 32'h00B3_8100);
    // R10 owner releases while local claims in the same clock
    step("R10", 1, 4'b0010, 32'h0000_0000, 1, 4'b0010, 32'h0000_9900);
    expect_word("R10", 32'h00B3_0000);
    // R2 local claims every free byte, layout per byte
    step("R2", 0, 4'b0000, 32'h0, 1, 4'b1111, 32'h8485_8687);
    expect_word("R2", 32'h84B3_8687);
    // R6 backplane cannot release local-owned semaphores
    step("R6", 1, 4'b1111, 32'h0000_0000, 0, 4'b0000, 32'h0);
    expect_word("R6", 32'h84B3_8687);
    // R11 read is whole word with byte enables idle; R8 idle cycle
    step("R11", 0, 4'b1111, 32'h0, 0, 4'b1111, 32'h0);
    expect_word("R11", 32'h84B3_8687);
    // R5 local releases all
    step("R5", 0, 4'b0000, 32'h0, 1, 4'b1111, 32'h0);
    expect_word("R5", 32'h0);

    // random traffic, narrow tags to provoke collisions (R3 R4 R5 R6 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      automatic logic [31:0] bw = $urandom & 32'h8383_8383;
      automatic logic [31:0] lw = $urandom & 32'h8383_8383;
      step("R10", 1'($urandom), 4'($urandom), bw, 1'($urandom), 4'($urandom), lw);
    end
    step("R8", 0, 4'b0000, 32'h0, 0, 4'b0000, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule